// File: doc/BRIEF.md
# Codebook-Indexed Multiply-Accumulate Unit

This unit computes dot products of operands that are stored as 4-bit indices into a fixed non-uniform value table. An index has no exponent or mantissa fields. Each cycle the unit can accept one pair of indices. It translates both indices through the table into signed fixed-point values, multiplies the two values, drops the low product bits so that they line up with the accumulator's fraction, and adds the result into a saturating 19-bit signed accumulator.

A clear flag that arrives with a pair starts a new dot product. A finish flag closes the current dot product. When the finish flag is sampled, the two unsigned per-group scale factors are captured. The accumulated sum is then multiplied by the product of those two scales, and the result is presented with a one-cycle valid pulse.

The sequencing is handled by a three-state controller. The states are:
- S_IDLE: no dot product is open.
- S_ACC: terms are being summed.
- S_SCALE: the closed sum is being multiplied by its scales.

The controller moves between the states as follows:
- S_IDLE to S_ACC when a term or a clear reaches the accumulator.
- S_IDLE or S_ACC to S_SCALE when a finish reaches the accumulator.
- S_SCALE to S_SCALE when another finish follows directly.
- S_SCALE to S_ACC when a term or a clear follows.
- S_SCALE to S_IDLE otherwise.

Top module: `lut_dq_mac`

## Requirements
- R1: Index to value mapping. The values are signed with 7 fraction bits, so +1.0 is clipped to 127. Indices 0 to 15 map to -128, -88, -64, -47, -34, -22, -11, 0, 9, 19, 30, 42, 56, 74, 98 and 127.
- R2: A pair accepted with `op_valid` high contributes the term (va*vb) arithmetically shifted right by 4 (rounded toward minus infinity). The accumulator therefore has 10 fraction bits.
- R3: The accumulator saturates at +262143 and at -262144 instead of wrapping. When a clamp occurs, `sat_flag` is set. The flag stays set until a clear.
- R4: `op_clear` together with `op_valid` loads the accumulator with the new term alone. `op_clear` without `op_valid` loads zero. Either form clears `sat_flag`.
- R5: A cycle with both `op_valid` and `op_clear` low leaves the accumulator unchanged, whatever the index inputs carry.
- R6: Each `op_last` produces one result equal to accumulator × `scale_a` × `scale_b`. The scales are unsigned and are taken in the same cycle as `op_last`. The accumulator value used includes any term given in that same cycle. `res_valid` is high for the cycle after the second rising edge that follows the edge sampling `op_last`. Back-to-back `op_last` cycles each produce their own result.
- R7: After reset, `res_valid` and `sat_flag` are low and the accumulator holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Index pair is present |
| op_clear | input | 1 | Start a new dot product |
| op_last | input | 1 | Close the dot product and capture the scales |
| code_a | input | 4 | First operand index |
| code_b | input | 4 | Second operand index |
| scale_a | input | 8 | Unsigned group scale of operand A |
| scale_b | input | 8 | Unsigned group scale of operand B |
| res_valid | output | 1 | One-cycle result strobe |
| res_value | output | 35 | Signed scaled sum |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The result is due exactly three sampling cycles after the cycle in which the driver presents `op_last`. There are three register stages on the way: operand lookup, accumulator and controller, and result. The driver stamps every expected item with that due cycle and pushes it into a queue. The monitor pops the item on each `res_valid` and compares the value, the arrival cycle and `sat_flag`. Because `sat_flag` is compared in that same cycle, any term given after `op_last` is either kept non-saturating or is preceded by idle cycles.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

    localparam int CODE_W = 4;
    localparam int VAL_W  = 8;

    typedef logic signed [VAL_W-1:0] val_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ACC   = 2'd1,
        S_SCALE = 2'd2
    } mac_state_e;

    // Non-uniform grid: dense near zero, sparse at the tails.
    function automatic val_t code_value(input logic [CODE_W-1:0] c);
        val_t v;
        v = '0;
        case (c)
            4'd0:  v = val_t'(-128);
            4'd1:  v = val_t'(-88);
            4'd2:  v = val_t'(-64);
            4'd3:  v = val_t'(-47);
            4'd4:  v = val_t'(-34);
            4'd5:  v = val_t'(-22);
            4'd6:  v = val_t'(-11);
            4'd7:  v = val_t'(0);
            4'd8:  v = val_t'(9);
            4'd9:  v = val_t'(19);
            4'd10: v = val_t'(30);
            4'd11: v = val_t'(42);
            4'd12: v = val_t'(56);
            4'd13: v = val_t'(74);
            4'd14: v = val_t'(98);
            4'd15: v = val_t'(127);
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lmac_lookup.sv
module lmac_lookup
    import lmac_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output val_t              value
);

    always_comb begin
        value = code_value(code);
    end

endmodule

// File: rtl/lmac_stage1.sv
module lmac_stage1
    import lmac_pkg::*;
#(
    parameter int SCALE_W = 8,
    localparam int PROD_W = 2 * VAL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic                     op_clear,
    input  logic                     op_last,
    input  logic [CODE_W-1:0]        code_a,
    input  logic [CODE_W-1:0]        code_b,
    input  logic [SCALE_W-1:0]       scale_a,
    input  logic [SCALE_W-1:0]       scale_b,
    output logic                     p_vld,
    output logic                     p_clr,
    output logic                     p_fin,
    output logic signed [PROD_W-1:0] p_prod,
    output logic [SCALE_W-1:0]       p_sa,
    output logic [SCALE_W-1:0]       p_sb
);

    val_t va;
    val_t vb;
    logic signed [PROD_W-1:0] prod_c;

    lmac_lookup u_lk_a (.code(code_a), .value(va));
    lmac_lookup u_lk_b (.code(code_b), .value(vb));

    always_comb begin
        prod_c = PROD_W'(va * vb);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_vld  <= 1'b0;
            p_clr  <= 1'b0;
            p_fin  <= 1'b0;
            p_prod <= '0;
            p_sa   <= '0;
            p_sb   <= '0;
        end else begin
            p_vld <= op_valid;
            p_clr <= op_clear;
            p_fin <= op_last;
            if (op_valid) begin
                p_prod <= prod_c;
            end
            if (op_last) begin
                p_sa <= scale_a;
                p_sb <= scale_b;
            end
        end
    end

endmodule

// File: rtl/lmac_accum.sv
module lmac_accum #(
    parameter int ACC_W  = 19,
    parameter int PROD_W = 16,
    parameter int DROP   = 4,
    localparam int SH_W  = PROD_W - DROP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     p_vld,
    input  logic                     p_clr,
    input  logic signed [PROD_W-1:0] p_prod,
    output logic signed [ACC_W-1:0]  acc,
    output logic                     sat
);

    localparam logic signed [ACC_W:0] MAXV = {2'b00, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] MINV = {2'b11, {(ACC_W-1){1'b0}}};

    logic signed [PROD_W-1:0] shifted;
    logic signed [ACC_W:0]    addend;
    logic signed [ACC_W:0]    base;
    logic signed [ACC_W:0]    sum;
    logic signed [ACC_W-1:0]  nxt;
    logic                     hit;

    always_comb begin
        shifted = p_prod >>> DROP;
        addend  = {{(ACC_W+1-SH_W){shifted[SH_W-1]}}, shifted[SH_W-1:0]};
        base    = p_clr ? '0 : {acc[ACC_W-1], acc};
        sum     = base + (p_vld ? addend : '0);
        hit     = 1'b0;
        nxt     = sum[ACC_W-1:0];
        if (sum > MAXV) begin
            nxt = MAXV[ACC_W-1:0];
            hit = 1'b1;
        end else if (sum < MINV) begin
            nxt = MINV[ACC_W-1:0];
            hit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            sat <= 1'b0;
        end else begin
            if (p_clr || p_vld) begin
                acc <= nxt;
            end
            if (p_clr) begin
                sat <= hit;
            end else if (p_vld && hit) begin
                sat <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lmac_ctrl.sv
module lmac_ctrl
    import lmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       p_vld,
    input  logic       p_clr,
    input  logic       p_fin,
    output mac_state_e state,
    output logic       do_scale
);

    mac_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (p_fin)              nxt = S_SCALE;
                else if (p_vld | p_clr) nxt = S_ACC;
            end
            S_ACC: begin
                if (p_fin)              nxt = S_SCALE;
            end
            S_SCALE: begin
                if (p_fin)              nxt = S_SCALE;
                else if (p_vld | p_clr) nxt = S_ACC;
                else                    nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        do_scale = (state == S_SCALE);
    end

endmodule

// File: rtl/lut_dq_mac.sv
module lut_dq_mac
    import lmac_pkg::*;
#(
    parameter int ACC_W   = 19,
    parameter int DROP    = 4,
    parameter int SCALE_W = 8,
    localparam int PROD_W = 2 * VAL_W,
    localparam int GAIN_W = 2 * SCALE_W,
    localparam int RES_W  = ACC_W + GAIN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_valid,
    input  logic                    op_clear,
    input  logic                    op_last,
    input  logic [CODE_W-1:0]       code_a,
    input  logic [CODE_W-1:0]       code_b,
    input  logic [SCALE_W-1:0]      scale_a,
    input  logic [SCALE_W-1:0]      scale_b,
    output logic                    res_valid,
    output logic signed [RES_W-1:0] res_value,
    output logic                    sat_flag
);

    logic                     p_vld;
    logic                     p_clr;
    logic                     p_fin;
    logic signed [PROD_W-1:0] p_prod;
    logic [SCALE_W-1:0]       p_sa;
    logic [SCALE_W-1:0]       p_sb;
    logic signed [ACC_W-1:0]  acc_q;
    mac_state_e               state;
    logic                     do_scale;
    logic [GAIN_W-1:0]        gain_q;
    logic signed [RES_W:0]    full;

    lmac_stage1 #(.SCALE_W(SCALE_W)) u_s1 (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_clear(op_clear), .op_last(op_last),
        .code_a(code_a), .code_b(code_b),
        .scale_a(scale_a), .scale_b(scale_b),
        .p_vld(p_vld), .p_clr(p_clr), .p_fin(p_fin),
        .p_prod(p_prod), .p_sa(p_sa), .p_sb(p_sb)
    );

    lmac_accum #(.ACC_W(ACC_W), .PROD_W(PROD_W), .DROP(DROP)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .p_vld(p_vld), .p_clr(p_clr), .p_prod(p_prod),
        .acc(acc_q), .sat(sat_flag)
    );

    lmac_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .p_vld(p_vld), .p_clr(p_clr), .p_fin(p_fin),
        .state(state), .do_scale(do_scale)
    );

    always_comb begin
        full = acc_q * $signed({1'b0, gain_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q    <= '0;
            res_valid <= 1'b0;
            res_value <= '0;
        end else begin
            if (p_fin) begin
                gain_q <= GAIN_W'(p_sa * p_sb);
            end
            res_valid <= do_scale;
            if (do_scale) begin
                res_value <= full[RES_W-1:0];
            end
        end
    end

endmodule

// File: rtl/lmac_chk.sv
module lmac_chk #(
    parameter int ACC_W = 19
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    op_last,
    input logic                    res_valid,
    input logic                    sat_flag,
    input logic                    p_vld,
    input logic                    p_clr,
    input logic signed [ACC_W-1:0] acc
);

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_last |-> ##3 res_valid);

    p_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(rst_n, 3)) |-> $past(op_last, 3));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !p_clr) |=> sat_flag);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        p_clr |=> !sat_flag);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_vld && !p_clr) |=> $stable(acc));

    p_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!res_valid && !sat_flag && acc == '0));

endmodule

bind lut_dq_mac lmac_chk #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_last(op_last),
    .res_valid(res_valid), .sat_flag(sat_flag),
    .p_vld(p_vld), .p_clr(p_clr), .acc(acc_q)
);

// File: tb/lut_dq_mac_tb.sv
`timescale 1ns/1ps
module lut_dq_mac_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_clear = 1'b0, op_last = 1'b0;
    logic [3:0]  code_a = '0, code_b = '0;
    logic [7:0]  scale_a = '0, scale_b = '0;
    logic        res_valid;
    logic signed [34:0] res_value;
    logic        sat_flag;

    always #2.5 clk = ~clk;

    lut_dq_mac u_dut (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_clear(op_clear), .op_last(op_last),
        .code_a(code_a), .code_b(code_b),
        .scale_a(scale_a), .scale_b(scale_b),
        .res_valid(res_valid), .res_value(res_value), .sat_flag(sat_flag)
    );

    typedef struct {
        longint val;
        bit     sat;
        int     due;
        string  tag;
    } exp_t;

    exp_t   sb_q[$];
    int     cyc = 0;
    int     checks = 0;
    int     fails = 0;
    longint acc_m = 0;
    bit     sat_m = 0;
    bit     done = 0;

    // R1 value table, written from the requirement
    int tbl [16] = '{-128, -88, -64, -47, -34, -22, -11, 0,
                     9, 19, 30, 42, 56, 74, 98, 127};

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic op(input int a, input int b, input bit v, input bit clr,
                      input bit last, input int sa, input int sb, input string tag);
        longint term;
        @(negedge clk);
        op_valid = v; op_clear = clr; op_last = last;
        code_a = 4'(a); code_b = 4'(b);
        scale_a = 8'(sa); scale_b = 8'(sb);
        term = longint'((tbl[a] * tbl[b]) >>> 4);   // R2 term
        if (clr) begin                               // R4
            acc_m = v ? term : 0;
            sat_m = 0;
        end else if (v) begin
            acc_m = acc_m + term;
        end
        if (acc_m > 262143) begin                    // R3
            acc_m = 262143; sat_m = 1;
        end else if (acc_m < -262144) begin
            acc_m = -262144; sat_m = 1;
        end
        if (last) begin
            exp_t e;
            e.val = acc_m * sa * sb;
            e.sat = sat_m;
            e.due = cyc + 3;
            e.tag = tag;
            sb_q.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 0; op_clear = 0; op_last = 0;
            code_a = 4'(i); code_b = 4'(15 - i);
        end
    endtask

    // monitor: pops the scoreboard on every result strobe
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb_q.size() == 0) begin
                check(0, "R6 unexpected result", res_value, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(res_value == e.val, {e.tag, " value"}, res_value, e.val);
                check(cyc == e.due, "R6 arrival cycle", cyc, e.due);
                check(sat_flag == e.sat, {e.tag, " sat_flag"}, sat_flag, e.sat);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(res_valid == 0, "R7 res_valid after reset", res_valid, 0);
        check(sat_flag == 0, "R7 sat_flag after reset", sat_flag, 0);

        // R7: finish alone straight after reset scales a zero sum
        op(0, 0, 0, 0, 1, 7, 9, "R7 empty sum");
        idle(4);

        // R1: every index against index 0 (-128), single-term products
        for (int i = 0; i < 16; i++) op(i, 0, 1, 1, 1, 1, 1, "R1 table");
        idle(4);

        // R2: multi-term product with scales
        op(14, 3, 1, 1, 0, 0, 0, "R2");
        op(6, 9, 1, 0, 0, 0, 0, "R2");
        op(1, 13, 1, 0, 0, 0, 0, "R2");
        op(11, 5, 1, 0, 1, 3, 5, "R2 dot product");
        idle(4);

        // R5: idle cycles with wandering indices leave the sum alone
        op(3, 12, 1, 1, 0, 0, 0, "R5");
        idle(5);
        op(5, 10, 1, 0, 0, 0, 0, "R5");
        idle(3);
        op(9, 9, 0, 0, 1, 2, 4, "R5 hold");
        idle(4);

        // R4: clear without a pair zeroes; then one term
        op(15, 15, 1, 1, 0, 0, 0, "R4");
        op(15, 15, 1, 0, 0, 0, 0, "R4");
        op(0, 0, 0, 1, 0, 0, 0, "R4");
        op(2, 13, 1, 0, 1, 1, 1, "R4 clear alone");
        idle(4);

        // R3: positive saturation with widest scales
        op(0, 0, 1, 1, 0, 0, 0, "R3");
        for (int i = 0; i < 299; i++) op(0, 0, 1, 0, 0, 0, 0, "R3");
        op(7, 7, 0, 0, 1, 255, 255, "R3 positive clamp");
        idle(4);

        // R3: negative saturation, flag sticky through a later term
        op(0, 15, 1, 1, 0, 0, 0, "R3");
        for (int i = 0; i < 299; i++) op(0, 15, 1, 0, 0, 0, 0, "R3");
        op(7, 7, 0, 0, 1, 2, 3, "R3 negative clamp");
        idle(4);
        op(15, 15, 1, 0, 1, 1, 1, "R3 sticky");
        idle(4);

        // R4: clear drops the saturation flag
        op(12, 10, 1, 1, 1, 4, 6, "R4 clear resets flag");
        idle(4);

        // R6: back-to-back finishes, distinct scales each
        op(13, 14, 1, 1, 1, 10, 11, "R6 back-to-back a");
        op(4, 8, 1, 0, 1, 20, 3, "R6 back-to-back b");
        op(10, 11, 1, 0, 1, 200, 150, "R6 back-to-back c");
        idle(6);

        check(sb_q.size() == 0, "R6 results outstanding", sb_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule